// File: doc/BRIEF.md
# Score and High-Score Multiplexed Display

This block keeps two scores for a game: the running score and the best score reached since reset. It shows both on an eight-digit common-anode seven-segment display. A single pulse input adds one to the running score, and a restart input sets the running score back to zero without touching the best score.

The display is time-multiplexed. A free-running counter picks which digit is lit, and only that digit's anode is pulled low. The four right-hand positions show the running score and the four left-hand positions show the best score. Each score is kept directly as four decimal (BCD) digits. Leading zeros are blanked, but the ones digit is always lit, so a zero score shows a single "0".

Top module: `score_display`

## Requirements
- R1: The scan counter is `CNT_W` bits wide (20 by default) and is cleared by reset. Its top three bits give the active position p (0..7). Exactly one anode line, bit p of `an_n`, is low, and that line changes only when the counter changes.
- R2: Positions 0..3 show the running score's ones, tens, hundreds and thousands digits. Positions 4..7 show the same digits of the best score.
- R3: `seg_n` is active-low, with bit 6 = segment a down to bit 0 = segment g. The digits 0..9 show as 0000001, 1001111, 0010010, 0000110, 1001100, 0100100, 0100000, 0001111, 0000000 and 0000100. A blank position shows 1111111.
- R4: A score digit above the ones digit is blank when it and every higher digit of the same score are zero. The ones digit is never blank.
- R5: Each clock cycle in which `apple_eaten` is high raises the running score by one. When `restart` is high in a cycle, the running score becomes zero, and restart wins over `apple_eaten`.
- R6: One cycle after the running score exceeds the best score, the best score takes the running score's value. The best score never decreases, and restart does not clear it.
- R7: The running score saturates at 9999, and further apple pulses leave it at 9999.
- R8: Synchronous active-low reset clears both scores and the scan counter. After reset, positions 0 and 4 show "0" and all other positions are blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| apple_eaten | input | 1 | Adds one to the running score in each cycle it is high |
| restart | input | 1 | Clears the running score |
| an_n | output | 8 | Digit anode enables, active low, one-cold |
| seg_n | output | 7 | Segment drive a..g, active low, a in bit 6 |

## Verification
A wrong BCD digit or a missed carry in either score register shows up as a wrong segment pattern the next time that digit's position is scanned, so it is seen within one full scan of eight positions. A best-score register that fails to capture, or that restart clears, shows at positions 4..7 during the first scan after the running score passes it. A stuck or skipped scan counter shows at once as a wrong anode line, because the bench keeps its own copy of the counter.

// File: rtl/score_disp_pkg.sv
// Shared constants and types for the score display.
// Assumes two scores of DIGITS BCD digits each, which together fill the eight display positions.
package score_disp_pkg;
    localparam int DIGITS = 4;
    localparam int NPOS   = 2 * DIGITS;
    localparam int SEL_W  = $clog2(NPOS);
    localparam int CODE_W = 5;
    localparam int SEG_W  = 7;
    localparam logic [CODE_W-1:0] CODE_BLANK = 5'd16;
    localparam logic [CODE_W-1:0] CODE_DASH  = 5'd17;
    typedef logic [DIGITS-1:0][3:0] score_t;
endpackage

// File: rtl/bcd_score_counter.sv
// BCD up-counter of NDIG digits, with a synchronous clear and saturation at all nines.
// Assumes clr has priority over inc, and that inc adds exactly one per cycle.
module bcd_score_counter #(
    parameter int NDIG = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 inc,
    input  logic                 clr,
    output logic [NDIG-1:0][3:0] val
);
    logic [NDIG:0]   carry;
    logic [NDIG-1:0] is_nine;
    logic            saturated;

    // Flag the digits that hold nine; the counter is saturated when all of them do.
    always_comb begin
        for (int i = 0; i < NDIG; i++) is_nine[i] = (val[i] == 4'd9);
        saturated = &is_nine;
        carry[0]  = inc & ~saturated;
    end

    for (genvar i = 0; i < NDIG; i++) begin : g_digit
        assign carry[i+1] = carry[i] & is_nine[i];

        // Step one decade digit when a carry reaches it, wrapping 9 back to 0.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)  val[i] <= 4'd0;
            else if (carry[i])  val[i] <= is_nine[i] ? 4'd0 : val[i] + 4'd1;
        end

        // R5: each digit stays a legal decimal digit
        a_r5_bcd_digit: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (val[i] <= 4'd9));
    end

    // R7: an increment at all nines leaves the value unchanged
    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (saturated && inc && !clr) |=> $stable(val));

    // R5: clear leaves the counter at zero
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (val == '0));
endmodule

// File: rtl/digit_scan.sv
// Free-running refresh counter whose top bits pick the lit display position.
// Assumes NPOS equals 2**SEL_W and that the anodes are active low.
module digit_scan #(
    parameter int CNT_W = 20,
    parameter int SEL_W = 3,
    parameter int NPOS  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SEL_W-1:0] sel,
    output logic [NPOS-1:0]  an_n
);
    logic [CNT_W-1:0] cnt;

    // Advance the refresh counter on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Take the active position from the counter's top bits and drive its anode low.
    always_comb begin
        sel  = cnt[CNT_W-1 -: SEL_W];
        an_n = ~(NPOS'(1) << sel);
    end

    // R1: exactly one anode enabled
    a_r1_one_anode: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(~an_n) == 1));

    // R1: the anode moves only when the counter's top bits move
    a_r1_anode_follows_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(sel) |-> $stable(an_n));
endmodule

// File: rtl/seg_decode.sv
// Decodes a 5-bit digit code to an active-low seven-segment pattern, with segment a in bit 6.
// Codes 0-9 are decimal digits, 10-15 hex letters, 16 blank, 17 a dash; any other code shows blank.
module seg_decode
    import score_disp_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [SEG_W-1:0]  seg_n
);
    // Look up the segment pattern for the code.
    always_comb begin
        case (code)
            5'd0:    seg_n = 7'b0000001;
            5'd1:    seg_n = 7'b1001111;
            5'd2:    seg_n = 7'b0010010;
            5'd3:    seg_n = 7'b0000110;
            5'd4:    seg_n = 7'b1001100;
            5'd5:    seg_n = 7'b0100100;
            5'd6:    seg_n = 7'b0100000;
            5'd7:    seg_n = 7'b0001111;
            5'd8:    seg_n = 7'b0000000;
            5'd9:    seg_n = 7'b0000100;
            5'd10:   seg_n = 7'b0001000;
            5'd11:   seg_n = 7'b1100000;
            5'd12:   seg_n = 7'b0110001;
            5'd13:   seg_n = 7'b1000010;
            5'd14:   seg_n = 7'b0110000;
            5'd15:   seg_n = 7'b0111000;
            CODE_DASH: seg_n = 7'b1111110;
            default: seg_n = 7'b1111111;
        endcase
    end
endmodule

// File: rtl/score_display.sv
// Running score and best score shown on an eight-digit multiplexed seven-segment display.
// Assumes apple_eaten is high one cycle per apple; restart clears only the running score.
module score_display
    import score_disp_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apple_eaten,
    input  logic             restart,
    output logic [NPOS-1:0]  an_n,
    output logic [SEG_W-1:0] seg_n
);
    score_t cur_score;
    score_t hi_score;
    score_t shown [2];
    logic [SEL_W-1:0] sel;
    logic [NPOS-1:0][CODE_W-1:0] codes;

    bcd_score_counter #(.NDIG(DIGITS)) cur_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (apple_eaten),
        .clr   (restart),
        .val   (cur_score)
    );

    // Copy the running score into the best score whenever it is larger (BCD order equals numeric order).
    always_ff @(posedge clk) begin
        if (!rst_n)                  hi_score <= '0;
        else if (cur_score > hi_score) hi_score <= cur_score;
    end

    assign shown[0] = cur_score;
    assign shown[1] = hi_score;

    for (genvar s = 0; s < 2; s++) begin : g_score
        logic [DIGITS:0] zero_up;
        assign zero_up[DIGITS] = 1'b1;
        for (genvar k = 0; k < DIGITS; k++) begin : g_pos
            assign zero_up[k] = (shown[s][k] == 4'd0) & zero_up[k+1];
            if (k == 0) begin : g_ones
                assign codes[s*DIGITS+k] = {1'b0, shown[s][k]};
            end else begin : g_upper
                assign codes[s*DIGITS+k] = zero_up[k] ? CODE_BLANK : {1'b0, shown[s][k]};
            end
        end
    end

    digit_scan #(.CNT_W(CNT_W), .SEL_W(SEL_W), .NPOS(NPOS)) scan_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .an_n  (an_n)
    );

    seg_decode dec_i (
        .code  (codes[sel]),
        .seg_n (seg_n)
    );

    // R6: the best score never decreases
    a_r6_hi_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hi_score >= $past(hi_score)));

    // R6: a larger running score is captured on the next edge
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_score > hi_score) |=> (hi_score == $past(cur_score)));
endmodule

// File: tb/score_display_tb_top.sv
// Self-checking bench: a cycle model of the counter and scores predicts every anode and segment value.
module score_display_tb_top;
    localparam int CNT_W = 6;
    localparam int TOP   = CNT_W - 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic apple_eaten = 1'b0;
    logic restart = 1'b0;
    logic [7:0] an_n;
    logic [6:0] seg_n;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    int m_cnt = 0;
    int m_cur = 0;
    int m_hi  = 0;

    always #4 clk = ~clk;

    score_display #(.CNT_W(CNT_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .apple_eaten (apple_eaten),
        .restart     (restart),
        .an_n        (an_n),
        .seg_n       (seg_n)
    );

    // Cycle model of R1, R5, R6, R7, R8.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_cur = 0; m_hi = 0;
        end else begin
            m_cnt = (m_cnt + 1) % (1 << CNT_W);
            if (m_cur > m_hi) m_hi = m_cur;
            if (restart) m_cur = 0;
            else if (apple_eaten && m_cur < 9999) m_cur = m_cur + 1;
        end
    end

    function automatic logic [6:0] digit_pat(input int d);
        case (d)
            0: return 7'b0000001;  1: return 7'b1001111;
            2: return 7'b0010010;  3: return 7'b0000110;
            4: return 7'b1001100;  5: return 7'b0100100;
            6: return 7'b0100000;  7: return 7'b0001111;
            8: return 7'b0000000;  9: return 7'b0000100;
            default: return 7'b1111111;
        endcase
    endfunction

    function automatic int pow10(input int k);
        int r = 1;
        for (int i = 0; i < k; i++) r = r * 10;
        return r;
    endfunction

    function automatic logic [6:0] exp_seg(input int pos, input int cur, input int hi);
        int v = (pos >= 4) ? hi : cur;
        int k = pos % 4;
        if (k > 0 && v < pow10(k)) return 7'b1111111;   // R4 blanking
        return digit_pat((v / pow10(k)) % 10);
    endfunction

    task automatic check(input string tag);
        int pos = (m_cnt >> TOP) & 7;
        logic [7:0] ea = ~(8'd1 << pos);
        logic [6:0] es = exp_seg(pos, m_cur, m_hi);
        n_vec++;
        if (an_n !== ea) begin
            n_bad++;
            $display("FAIL R1 [%s] anode got %b expected %b", tag, an_n, ea);
        end
        if (seg_n !== es) begin
            n_bad++;
            $display("FAIL R2 R3 R4 [%s] pos %0d cur %0d hi %0d seg got %b expected %b",
                     tag, pos, m_cur, m_hi, seg_n, es);
        end
    endtask

    task automatic step(input string tag, input logic a, input logic r);
        @(negedge clk);
        check(tag);
        apple_eaten = a;
        restart = r;
    endtask

    initial begin
        void'($urandom(32'd20250407));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: after reset only positions 0 and 4 show "0"
        for (int i = 0; i < 64; i++) step("R8 reset", 1'b0, 1'b0);
        // R5 R6: 120 apples, restart, then fewer apples so the best score stays ahead
        for (int i = 0; i < 120; i++) step("R5 count", 1'b1, 1'b0);
        step("R5 restart", 1'b0, 1'b1);
        for (int i = 0; i < 50; i++) step("R6 hold", 1'b1, 1'b0);
        for (int i = 0; i < 64; i++) step("R6 hold", 1'b0, 1'b0);
        // R5: restart together with apple
        step("R5 restart wins", 1'b1, 1'b1);
        for (int i = 0; i < 64; i++) step("R5 restart wins", 1'b0, 1'b0);
        // R5 R6: random apples and rare restarts
        for (int i = 0; i < 4000; i++)
            step("R6 random", ($urandom % 3) == 0, ($urandom % 300) == 0);
        // R7: drive well past 9999
        for (int i = 0; i < 10100; i++) step("R7 saturate", 1'b1, 1'b0);
        for (int i = 0; i < 64; i++) step("R7 saturate", 1'b0, 1'b0);
        // R6: restart keeps the best score at 9999
        step("R6 restart keeps best", 1'b0, 1'b1);
        for (int i = 0; i < 64; i++) step("R6 restart keeps best", 1'b0, 1'b0);
        // R8: reset in mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 64; i++) step("R8 re-reset", 1'b0, 1'b0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired got running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule